// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block gathers single-cycle event strobes from five interrupt sources: an external pin edge, a converter reload, a timer-1 overflow, a port transition and a base-timer overflow. Each strobe sets a sticky pending flag. A flag counts as eligible only when its own enable bit is set and the processor's global mask input is clear. When at least one source is eligible, the block registers an interrupt request and selects one winner by fixed priority. It then presents the 16-bit address of the low byte of that winner's vector pair.

Toward the CPU, `irq_o` and `ack_i` act as a valid/ready pair, and `vec_o` is the payload. Once `irq_o` is high, the block holds `irq_o` and `vec_o` unchanged until the core raises `ack_i`. This is the back-pressure rule: the core may stall for as long as it needs, and the winner is never replaced while it waits. On acknowledge, the block clears the winner's flag and pulses `mask_set_o` so the core sets its global mask. It then drops `irq_o` for at least one cycle. Software reads the flags and enables through a small register port, writes the enables, and clears flags by writing ones.

Top module: `irq_vec_ctrl`

## Requirements
- R1: An event strobe on `evt_i[k]` sets pending flag k at the next clock edge. The source indices are: 0 external pin, 1 converter reload, 2 timer 1, 3 port transition, 4 base timer.
- R2: A pending flag stays set until one of two things happens: a register write with `reg_addr`=0 carries a 1 in its bit, or the source is acknowledged. Writing a 0 to a flag bit has no effect on it.
- R3: An event arriving in the same cycle as a software clear of the same flag leaves the flag set.
- R4: A write with `reg_addr`=1 loads the enable bits. `reg_rdata` returns the pending flags when `reg_addr`=0 and the enable bits when `reg_addr`=1. Both registers reset to zero.
- R5: A source is eligible only when its flag is set, its enable bit is set and `mask_i` is low. `irq_o` rises one clock after a source becomes eligible while no request is outstanding. A pending but disabled or masked source never raises `irq_o`.
- R6: When several sources are eligible, the winner is the lowest index: external pin first, then converter reload, timer 1, port transition and base timer.
- R7: While `irq_o` is high, `vec_o` gives the low-byte vector address of the winner: 16'hFFF8 for source 0, FFF6 for source 1, FFF2 for source 2, FFF0 for source 3 and FFEE for source 4. `vec_o` is zero while `irq_o` is low.
- R8: Once `irq_o` is high, it and `vec_o` stay unchanged every cycle until `ack_i` is high. This holds even if the mask rises or the flag is cleared in the meantime.
- R9: A cycle with both `irq_o` and `ack_i` high does three things: it raises `mask_set_o` in that cycle, it clears the winner's flag, and it forces `irq_o` low in the next cycle.
- R10: The reserved addresses FFF4 and FFFA, and the reset address FFFC, never appear on `vec_o` while `irq_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 5 | Event strobes, one bit per source |
| mask_i | input | 1 | Global interrupt mask from the CPU |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects flags (write-1-to-clear), 1 selects enables |
| reg_wdata | input | 5 | Register write data |
| reg_rdata | output | 5 | Register read data for `reg_addr` |
| irq_o | output | 1 | Interrupt request (valid) |
| vec_o | output | 16 | Vector low-byte address (payload) |
| ack_i | input | 1 | Acknowledge from CPU (ready) |
| mask_set_o | output | 1 | Pulse telling the CPU to set its mask |

## Verification
A corrupted pending flag appears on `reg_rdata` in the very next cycle. One clock later it shows up again as a spurious, missing or mis-prioritised vector. A latched winner that drifts breaks the hold rule and changes `vec_o` while `irq_o` waits for acknowledge. A wrong acknowledge clear leaves the same vector returning on the following request, two cycles after the handshake.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NSRC  = 5;
  localparam int IDX_W = $clog2(NSRC);
  localparam int VEC_W = 16;

  typedef logic [IDX_W-1:0] src_idx_t;

  // Low-byte address of each source's vector pair, sorted by priority.
  function automatic logic [VEC_W-1:0] vec_of(src_idx_t s);
    case (s)
      3'd0:    return 16'hFFF8;
      3'd1:    return 16'hFFF6;
      3'd2:    return 16'hFFF2;
      3'd3:    return 16'hFFF0;
      3'd4:    return 16'hFFEE;
      default: return 16'hFFF8;
    endcase
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] sw_clr,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] pend
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend[g] <= 1'b0;
        else        pend[g] <= evt[g] | (pend[g] & ~sw_clr[g] & ~ack_clr[g]);
      end
    end
  endgenerate
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N     = 5,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  logic [N:0]   seen;
  logic [N-1:0] grant;

  assign seen[0] = 1'b0;
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chain
      assign grant[g]  = req[g] & ~seen[g];
      assign seen[g+1] = seen[g] | req[g];
    end
  endgenerate

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (grant[i]) idx = IDX_W'(i);
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int VW = VEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  evt_i,
  input  logic          mask_i,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [N-1:0]  reg_wdata,
  output logic [N-1:0]  reg_rdata,
  output logic          irq_o,
  output logic [VW-1:0] vec_o,
  input  logic          ack_i,
  output logic          mask_set_o
);
  localparam int IW = $clog2(N);

  logic [N-1:0]  en_q;
  logic [N-1:0]  pend_q;
  logic [N-1:0]  sw_clr;
  logic [N-1:0]  ack_clr;
  logic [N-1:0]  elig;
  logic          any_elig;
  logic [IW-1:0] pick_idx;
  logic          irq_q;
  logic [IW-1:0] win_q;
  logic          ack_hit;

  assign sw_clr  = (reg_wr && !reg_addr) ? reg_wdata : '0;
  assign ack_hit = irq_q & ack_i;
  assign ack_clr = ack_hit ? (N'(1) << win_q) : '0;
  assign elig    = pend_q & en_q & {N{~mask_i}};

  irq_pend_bank #(.N(N)) bank_i (
    .clk(clk), .rst_n(rst_n), .evt(evt_i),
    .sw_clr(sw_clr), .ack_clr(ack_clr), .pend(pend_q)
  );

  irq_prio_pick #(.N(N), .IDX_W(IW)) pick_i (
    .req(elig), .any(any_elig), .idx(pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      en_q <= '0;
    else if (reg_wr && reg_addr)     en_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      win_q <= '0;
    end else if (ack_hit) begin
      irq_q <= 1'b0;
    end else if (!irq_q) begin
      irq_q <= any_elig;
      win_q <= pick_idx;
    end
  end

  assign irq_o      = irq_q;
  assign vec_o      = irq_q ? vec_of(win_q) : '0;
  assign mask_set_o = ack_hit;
  assign reg_rdata  = reg_addr ? en_q : pend_q;
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk #(
  parameter int N  = 5,
  parameter int VW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  evt_i,
  input logic          mask_i,
  input logic          ack_i,
  input logic          irq_o,
  input logic [VW-1:0] vec_o,
  input logic          mask_set_o,
  input logic [N-1:0]  pend
);
  // R1
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((pend & $past(evt_i)) == $past(evt_i)));

  // R5
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && mask_i) |=> !irq_o);

  // R8
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_i) |=> (irq_o && $stable(vec_o)));

  // R9
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ack_i) |=> !irq_o);

  // R9
  mask_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_set_o |-> (irq_o && ack_i));

  // R10
  no_rsvd_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_o != 16'hFFF4 && vec_o != 16'hFFFA && vec_o != 16'hFFFC));

  // R7
  idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (vec_o == '0));
endmodule

bind irq_vec_ctrl irq_vec_chk #(.N(N), .VW(VW)) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .mask_i(mask_i), .ack_i(ack_i),
  .irq_o(irq_o), .vec_o(vec_o), .mask_set_o(mask_set_o), .pend(pend_q)
);

// File: tb/irq_vec_ctrl_tb_top.sv
module irq_vec_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  evt_i = '0;
  logic        mask_i = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [4:0]  reg_wdata = '0;
  logic [4:0]  reg_rdata;
  logic        irq_o;
  logic [15:0] vec_o;
  logic        ack_i = 1'b0;
  logic        mask_set_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_vec_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .mask_i(mask_i),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o), .vec_o(vec_o),
    .ack_i(ack_i), .mask_set_o(mask_set_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [4:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic a, output logic [4:0] d);
    reg_addr = a; #1; d = reg_rdata; reg_addr = 1'b0;
  endtask

  task automatic pulse(logic [4:0] e);
    evt_i = e; @(negedge clk); evt_i = '0;
  endtask

  task automatic t_reset();
    logic [4:0] d;
    rd(1'b0, d); chk("R4 flags reset", 32'(d), 0);
    rd(1'b1, d); chk("R4 enables reset", 32'(d), 0);
    chk("R5 irq reset", 32'(irq_o), 0);
    chk("R7 vec idle", 32'(vec_o), 0);
  endtask

  task automatic t_enables();
    logic [4:0] d;
    wr(1'b1, 5'h1A); rd(1'b1, d); chk("R4 enable rw", 32'(d), 32'h1A);
    wr(1'b1, 5'h00); rd(1'b1, d); chk("R4 enable clear", 32'(d), 0);
  endtask

  task automatic t_flags();
    logic [4:0] d;
    pulse(5'b10101); rd(1'b0, d); chk("R1 flags set", 32'(d), 32'h15);
    @(negedge clk); chk("R5 disabled no irq", 32'(irq_o), 0);
    wr(1'b0, 5'b00001); rd(1'b0, d); chk("R2 w1c", 32'(d), 32'h14);
    wr(1'b0, 5'b00000); rd(1'b0, d); chk("R2 write 0 ignored", 32'(d), 32'h14);
    @(negedge clk); rd(1'b0, d); chk("R2 sticky", 32'(d), 32'h14);
    wr(1'b0, 5'h1F); rd(1'b0, d); chk("R2 clear all", 32'(d), 0);
  endtask

  task automatic t_collide();
    logic [4:0] d;
    evt_i = 5'b00100; reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 5'b00100;
    @(negedge clk);
    evt_i = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd(1'b0, d); chk("R3 event beats clear", 32'(d), 32'h04);
    wr(1'b0, 5'h1F);
  endtask

  task automatic t_mask();
    mask_i = 1'b1;
    wr(1'b1, 5'h1F);
    pulse(5'h1F);
    @(negedge clk); chk("R5 masked no irq", 32'(irq_o), 0);
    mask_i = 1'b0;
    @(negedge clk); chk("R5 irq after unmask", 32'(irq_o), 1);
    chk("R6 top priority", 32'(vec_o), 32'hFFF8);
  endtask

  task automatic t_order();
    logic [15:0] exp_v [5] = '{16'hFFF8, 16'hFFF6, 16'hFFF2, 16'hFFF0, 16'hFFEE};
    logic [4:0] d;
    for (int k = 0; k < 5; k++) begin
      chk("R7 vector order", 32'(vec_o), 32'(exp_v[k]));
      mask_i = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8 irq held", 32'(irq_o), 1);
      chk("R8 vec held", 32'(vec_o), 32'(exp_v[k]));
      chk("R10 not reserved", 32'(vec_o == 16'hFFF4 || vec_o == 16'hFFFA), 0);
      ack_i = 1'b1; #1;
      chk("R9 mask pulse", 32'(mask_set_o), 1);
      @(negedge clk); ack_i = 1'b0; mask_i = 1'b0;
      chk("R9 irq drops", 32'(irq_o), 0);
      rd(1'b0, d); chk("R9 winner cleared", 32'(d), 32'h1F & ~((32'h1F >> (k + 1)) << (k + 1)) ^ 32'h1F);
      @(negedge clk);
      chk("R5 next request", 32'(irq_o), (k < 4) ? 1 : 0);
    end
    chk("R7 vec idle after", 32'(vec_o), 0);
  endtask

  task automatic t_pair();
    wr(1'b1, 5'b11010);
    pulse(5'b11001);
    @(negedge clk);
    chk("R6 enabled winner", 32'(vec_o), 32'hFFF0);
    ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
    @(negedge clk);
    chk("R6 next winner", 32'(vec_o), 32'hFFEE);
    wr(1'b0, 5'h1F);
    chk("R8 held after sw clear", 32'(irq_o), 1);
    ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
    @(negedge clk);
    chk("R5 idle after", 32'(irq_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enables();
    t_flags();
    t_collide();
    t_mask();
    t_order();
    t_pair();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule